// File: doc/BRIEF.md
# Backlight PWM Generator with Selectable Step Prescaler

This block drives a panel backlight with a pulse-width-modulated signal timed from a fixed 24 MHz reference clock. Software sets a period and a duty value as counts of PWM steps. A step lasts either 16 or 128 reference cycles, selected by one control bit. The output is active for the first `duty` steps of each period and inactive for the rest. A polarity bit chooses between an active-high and an active-low output.

The duty count can come from one of two places. One is the local register. The other is an input port driven by an upstream controller, and a control bit selects between them. Period, duty and step select are first written into a staging word. The counters only pick these values up when a period ends, so a rewrite in mid-period cannot shorten or split a pulse. While the generator is stopped, the live values follow the staging word directly.

Software computes the period itself. With 16-cycle steps, a period count of 7500 gives 200 Hz, and a duty count of 3750 then gives half brightness.

Top module: `bl_pwm_top`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, the output is low, and the counters are idle.
- R2: The register map is as follows. Address 0 is control: bit 31 enable, bit 30 local-duty select, bit 29 polarity, bit 0 long step. Address 1 is the staging word, with the period in bits 31:16 and the duty in bits 15:0. Address 2 is the read-only live word, holding the period in use and the duty in use in the same bit positions. Other addresses read zero. Read data is combinational from the address.
- R3: One step lasts 16 reference cycles when control bit 0 is clear and 128 when it is set. A full period lasts period × step reference cycles.
- R4: While enable is clear, or while the live period is 0, the output holds its inactive level.
- R5: A live duty of 0 keeps the output inactive. A live duty greater than or equal to the live period keeps it active for the whole period.
- R6: Within each period the output is active while the step count is below the live duty. Over k whole periods it is therefore active for k × duty × step cycles.
- R7: With polarity set, the output is inverted: it rests high and pulses low. With polarity clear, it rests low. Polarity takes effect without waiting for a period end.
- R8: With control bit 30 set, the duty comes from the staging word. With it clear, the duty comes from the `ext_duty` input. The selected value is captured at a period end.
- R9: Period, duty and step select written to the staging word reach the live word only at the end of the current period. While stopped, the live word takes the staged values on the cycle after they change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 24 MHz reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 2 | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| ext_duty | input | 16 | Duty count from the upstream controller |
| pwm_out | output | 1 | Backlight PWM output |

## Verification
A read returns its value in the same cycle as the address. A write shows in the control and staging words one edge later. The live word changes only at the next period end, or one edge after the write when the generator is stopped. The output is registered, so it lags the step counter by one cycle. Duty and period checks are therefore made only after a settle time longer than two of the longest periods. Each check counts active output cycles over a window of whole periods, and that count does not depend on the phase at which the window opens. The staging check starts its write just after a rising output edge, which leaves most of a period before the boundary.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;

    // default geometry
    localparam int unsigned CNT_W_DEF      = 16;
    localparam int unsigned ADDR_W_DEF     = 2;
    localparam int unsigned STEP_SHORT_DEF = 16;
    localparam int unsigned STEP_LONG_DEF  = 128;

    // register addresses
    localparam int unsigned ADDR_CTRL  = 0;
    localparam int unsigned ADDR_STAGE = 1;
    localparam int unsigned ADDR_LIVE  = 2;

    // control word bit positions
    localparam int unsigned BIT_EN   = 31;
    localparam int unsigned BIT_LOC  = 30;
    localparam int unsigned BIT_POL  = 29;
    localparam int unsigned BIT_LONG = 0;

    typedef struct packed {
        logic en;        // generator running
        logic loc;       // use local duty instead of ext_duty
        logic pol;       // active-low output when set
        logic step_long; // 128-cycle step when set
    } ctrl_t;

endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
    import bl_pwm_pkg::*;
#(
    parameter int unsigned CNT_W  = CNT_W_DEF,
    parameter int unsigned ADDR_W = ADDR_W_DEF,
    localparam int unsigned DATA_W = 2 * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [CNT_W-1:0]  live_per,
    input  logic [CNT_W-1:0]  live_duty,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  stg_per,
    output logic [CNT_W-1:0]  stg_duty
);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] duty;
    } reg_state_t;

    reg_state_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            if (addr == ADDR_W'(ADDR_CTRL)) begin
                r_d.ctrl.en        = wdata[BIT_EN];
                r_d.ctrl.loc       = wdata[BIT_LOC];
                r_d.ctrl.pol       = wdata[BIT_POL];
                r_d.ctrl.step_long = wdata[BIT_LONG];
            end else if (addr == ADDR_W'(ADDR_STAGE)) begin
                r_d.per  = wdata[DATA_W-1:CNT_W];
                r_d.duty = wdata[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // combinational readback
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADDR_CTRL)) begin
            rdata[BIT_EN]   = r_q.ctrl.en;
            rdata[BIT_LOC]  = r_q.ctrl.loc;
            rdata[BIT_POL]  = r_q.ctrl.pol;
            rdata[BIT_LONG] = r_q.ctrl.step_long;
        end else if (addr == ADDR_W'(ADDR_STAGE)) begin
            rdata = {r_q.per, r_q.duty};
        end else if (addr == ADDR_W'(ADDR_LIVE)) begin
            rdata = {live_per, live_duty};
        end
    end

    assign ctrl     = r_q.ctrl;
    assign stg_per  = r_q.per;
    assign stg_duty = r_q.duty;

endmodule

// File: rtl/bl_pwm_timebase.sv
module bl_pwm_timebase #(
    parameter int unsigned CNT_W      = bl_pwm_pkg::CNT_W_DEF,
    parameter int unsigned STEP_SHORT = bl_pwm_pkg::STEP_SHORT_DEF,
    parameter int unsigned STEP_LONG  = bl_pwm_pkg::STEP_LONG_DEF,
    localparam int unsigned PRE_W     = $clog2(STEP_LONG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             stg_long,
    input  logic [CNT_W-1:0] stg_per,
    input  logic [CNT_W-1:0] duty_sel,
    output logic             running,
    output logic             load,
    output logic [PRE_W-1:0] pre,
    output logic             live_long,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] live_per,
    output logic [CNT_W-1:0] live_duty
);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] duty;
        logic             lng;
    } tb_state_t;

    tb_state_t t_d, t_q;

    logic [PRE_W-1:0] step_last;
    logic             step_end;
    logic             period_end;

    assign step_last  = t_q.lng ? PRE_W'(STEP_LONG - 1) : PRE_W'(STEP_SHORT - 1);
    assign running    = en && (t_q.per != '0);
    assign step_end   = (t_q.pre == step_last);
    assign period_end = step_end && (t_q.cnt == t_q.per - CNT_W'(1));
    assign load       = !running || period_end;

    always_comb begin
        t_d = t_q;
        if (!running) begin
            t_d.pre = '0;
            t_d.cnt = '0;
        end else if (step_end) begin
            t_d.pre = '0;
            t_d.cnt = period_end ? '0 : t_q.cnt + CNT_W'(1);
        end else begin
            t_d.pre = t_q.pre + PRE_W'(1);
        end
        // shadow transfer at a period boundary or while stopped
        if (load) begin
            t_d.per  = stg_per;
            t_d.duty = duty_sel;
            t_d.lng  = stg_long;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign pre       = t_q.pre;
    assign cnt       = t_q.cnt;
    assign live_per  = t_q.per;
    assign live_duty = t_q.duty;
    assign live_long = t_q.lng;

endmodule

// File: rtl/bl_pwm_outstage.sv
module bl_pwm_outstage #(
    parameter int unsigned CNT_W = bl_pwm_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             pol,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] duty,
    output logic             pwm
);

    typedef struct packed {
        logic pwm;
    } out_state_t;

    out_state_t o_d, o_q;

    always_comb begin
        o_d     = o_q;
        o_d.pwm = pol ^ (running && (cnt < duty));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign pwm = o_q.pwm;

endmodule

// File: rtl/bl_pwm_top.sv
module bl_pwm_top
    import bl_pwm_pkg::*;
#(
    parameter int unsigned CNT_W      = CNT_W_DEF,
    parameter int unsigned ADDR_W     = ADDR_W_DEF,
    parameter int unsigned STEP_SHORT = STEP_SHORT_DEF,
    parameter int unsigned STEP_LONG  = STEP_LONG_DEF,
    localparam int unsigned DATA_W    = 2 * CNT_W,
    localparam int unsigned PRE_W     = $clog2(STEP_LONG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [CNT_W-1:0]  ext_duty,
    output logic              pwm_out
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] stg_per, stg_duty, duty_sel;
    logic [CNT_W-1:0] live_per, live_duty, cnt;
    logic [PRE_W-1:0] pre;
    logic             running, load, live_long;
    logic             en_w, pol_w;

    assign en_w     = ctrl.en;
    assign pol_w    = ctrl.pol;
    assign duty_sel = ctrl.loc ? stg_duty : ext_duty;

    bl_pwm_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (reg_addr),
        .we       (reg_we),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .live_per (live_per),
        .live_duty(live_duty),
        .ctrl     (ctrl),
        .stg_per  (stg_per),
        .stg_duty (stg_duty)
    );

    bl_pwm_timebase #(.CNT_W(CNT_W), .STEP_SHORT(STEP_SHORT), .STEP_LONG(STEP_LONG)) u_tbase (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_w),
        .stg_long (ctrl.step_long),
        .stg_per  (stg_per),
        .duty_sel (duty_sel),
        .running  (running),
        .load     (load),
        .pre      (pre),
        .live_long(live_long),
        .cnt      (cnt),
        .live_per (live_per),
        .live_duty(live_duty)
    );

    bl_pwm_outstage #(.CNT_W(CNT_W)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .running(running),
        .pol    (pol_w),
        .cnt    (cnt),
        .duty   (live_duty),
        .pwm    (pwm_out)
    );

endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk #(
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned STEP_SHORT = 16,
    parameter int unsigned STEP_LONG  = 128,
    parameter int unsigned PRE_W      = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pol,
    input logic             running,
    input logic             load,
    input logic [PRE_W-1:0] pre,
    input logic             live_long,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] live_per,
    input logic [CNT_W-1:0] live_duty,
    input logic             pwm_out
);

    // R3: prescaler never exceeds the selected step length
    a_r3_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pre < (live_long ? PRE_W'(STEP_LONG - 1) : PRE_W'(STEP_SHORT - 1)) ||
        pre == (live_long ? PRE_W'(STEP_LONG - 1) : PRE_W'(STEP_SHORT - 1)));

    // R6: step count stays inside the live period
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt < live_per));

    // R6: a period end restarts the step count
    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (running && load) |=> (cnt == '0));

    // R9: live values only change on a load
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(live_per) && $stable(live_duty) && $stable(live_long)));

    // R4: stopped generator rests at the inactive level
    a_r4_idle_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> (pwm_out == $past(pol)));

    // R5: zero duty gives an inactive output
    a_r5_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
        (running && live_duty == '0) |=> (pwm_out == $past(pol)));

    // R5: duty at or above period gives an active output
    a_r5_full_duty: assert property (@(posedge clk) disable iff (!rst_n)
        (running && live_duty >= live_per) |=> (pwm_out != $past(pol)));

endmodule

bind bl_pwm_top bl_pwm_chk #(
    .CNT_W(CNT_W), .STEP_SHORT(STEP_SHORT), .STEP_LONG(STEP_LONG), .PRE_W(PRE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pol      (pol_w),
    .running  (running),
    .load     (load),
    .pre      (pre),
    .live_long(live_long),
    .cnt      (cnt),
    .live_per (live_per),
    .live_duty(live_duty),
    .pwm_out  (pwm_out)
);

// File: tb/test_bl_pwm_top.sv
`timescale 1ns/1ps
module test_bl_pwm_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] ext_duty = '0;
    logic        pwm_out;

    int n_vec = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bl_pwm_top i_bl_pwm_top (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_duty(ext_duty),
        .pwm_out(pwm_out)
    );

    typedef struct {
        string tag;
        int    window;
        int    exp_high;
    } item_t;

    item_t sb_q[$];

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(string tag, logic [1:0] a, logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic settle();
        repeat (1200) @(negedge clk);
    endtask

    // driver side: queue an expected active-cycle count, wait for the monitor
    task automatic measure(string tag, int window, int exp_high);
        item_t it;
        it.tag = tag; it.window = window; it.exp_high = exp_high;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    // monitor: counts high output cycles over the window and compares
    initial begin
        forever begin
            item_t it;
            int hi;
            wait (sb_q.size() > 0);
            it = sb_q[0];
            hi = 0;
            repeat (it.window) begin
                @(negedge clk);
                if (pwm_out) hi++;
            end
            check(it.tag, hi, it.exp_high);
            void'(sb_q.pop_front());
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 output after reset", {31'd0, pwm_out}, 32'd0);
        rd_check("R1 ctrl reset", 2'd0, 32'h0);
        rd_check("R1 stage reset", 2'd1, 32'h0);
        rd_check("R1 live reset", 2'd2, 32'h0);

        // R2: map and readback
        wr(2'd0, 32'hC000_0000);
        wr(2'd1, {16'd8, 16'd3});
        rd_check("R2 ctrl readback", 2'd0, 32'hC000_0000);
        rd_check("R2 stage readback", 2'd1, 32'h0008_0003);
        rd_check("R2 unmapped reads zero", 2'd3, 32'h0);
        settle();
        rd_check("R9 live follows stage", 2'd2, 32'h0008_0003);

        // R6: 3 of 8 short steps, two periods
        measure("R6 duty 3/8", 256, 96);

        // R5: extremes
        wr(2'd1, {16'd8, 16'd0});
        settle();
        measure("R5 zero duty", 256, 0);
        wr(2'd1, {16'd8, 16'd10});
        settle();
        measure("R5 duty above period", 256, 256);

        // R4: zero period and enable clear
        wr(2'd1, {16'd0, 16'd3});
        settle();
        measure("R4 zero period", 256, 0);
        wr(2'd1, {16'd8, 16'd3});
        wr(2'd0, 32'h4000_0000);
        settle();
        measure("R4 enable clear", 256, 0);

        // R7: polarity
        wr(2'd0, 32'hE000_0000);
        settle();
        measure("R7 inverted duty 3/8", 256, 160);
        wr(2'd0, 32'h6000_0000);
        settle();
        measure("R7 inverted idle rests high", 256, 256);

        // R3: long vs short step with period 4, duty 1
        wr(2'd0, 32'hC000_0001);
        wr(2'd1, {16'd4, 16'd1});
        settle();
        measure("R3 long step", 1024, 256);
        wr(2'd0, 32'hC000_0000);
        settle();
        measure("R3 short step", 128, 32);

        // R8: external duty selection
        ext_duty = 16'd5;
        wr(2'd1, {16'd8, 16'd2});
        wr(2'd0, 32'h8000_0000);
        settle();
        measure("R8 external duty", 256, 160);
        rd_check("R8 live shows external duty", 2'd2, 32'h0008_0005);
        wr(2'd0, 32'hC000_0000);
        settle();
        measure("R8 local duty", 256, 64);

        // R9: staged write waits for period end
        wr(2'd1, {16'd8, 16'd3});
        settle();
        @(posedge pwm_out);
        wr(2'd1, {16'd8, 16'd6});
        rd_check("R9 live held mid-period", 2'd2, 32'h0008_0003);
        rd_check("R9 stage updated", 2'd1, 32'h0008_0006);
        repeat (300) @(negedge clk);
        rd_check("R9 live after period end", 2'd2, 32'h0008_0006);
        measure("R9 new duty in effect", 256, 192);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

endmodule